// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A register-mapped general-purpose I/O block for up to 32 lines. Software sets each line's direction, drives output bits through atomic set, clear and toggle registers, and reads back live line levels. The inputs pass through a two-flop synchroniser inside the block before anything else uses them.

Each line can raise a pending flag on a rising transition, a falling transition, or both, under two independent enable masks. Pending flags persist until software writes ones to clear them. A companion register records the direction of the last captured edge of each pending line. A polarity mask inverts the sense of input lines. One level interrupt output is high while any flag is pending.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word offsets are 0 pending status, 1 edge direction, 2 rising enable, 3 falling enable, 4 data, 5 direction, 6 polarity, 7 set, 8 clear, 9 toggle. After reset every register, `pin_out`, `pin_oe` and `irq` are zero.
- R2: A write of ones to offset 7 forces those output bits to 1, to offset 8 forces them to 0, and to offset 9 inverts them. Zero bits leave the output unchanged. A write to offset 4 loads the output register directly.
- R3: Direction bit 1 makes the line an output (`pin_oe` bit 1). Reading offset 4 returns the output register bit for output lines and the synchronised, polarity-adjusted level for input lines. A pin change sampled at clock edge k is visible after edge k+1.
- R4: A rising transition of the adjusted level sets the line's pending bit only if its rising-enable bit is 1.
- R5: A falling transition sets the pending bit only if its falling-enable bit is 1. With both enables set, either transition sets it.
- R6: Writing 1 to a pending-status bit clears it. Writing 0 leaves it unchanged.
- R7: If an edge is detected in the same cycle as a clearing write to that bit, the bit stays set.
- R8: The edge-direction bit is 1 if the line's last captured edge was rising and 0 if it was falling. It is 0 whenever the pending bit is 0. Writes to offset 1 are ignored.
- R9: `irq` is a registered OR of the pending bits. It rises one cycle after a bit becomes pending, which is edge k+3 for a pin change sampled at edge k. It falls one cycle after the last bit is cleared.
- R10: A polarity bit of 1 inverts that input line for data reads and edge detection. Changing polarity does not by itself create an edge.
- R11: Offsets 7, 8, 9 and the unused offsets 10 to 15 read as zero. Writes to unused offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| addr | input | 4 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| pin_in | input | 32 | Raw line levels |
| pin_out | output | 32 | Output register |
| pin_oe | output | 32 | Per-line output enable |
| irq | output | 1 | Level interrupt |

## Verification
Directed sequences drive single-line edges under each enable combination: rising only, falling only, both, and none. These separate the two enable masks from each other and record the edge direction. A falling edge timed to meet a clearing write in the same cycle shows whether the edge beats the clear. Polarity and direction masks applied to a fixed pin pattern expose per-bit muxing of the data read. A long random run mixes writes to every offset with sparse pin flips, and compares each read, the outputs and the interrupt against a cycle model every cycle.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NL = 32,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NL-1:0] pin_in,
  output logic [NL-1:0] pin_out,
  output logic [NL-1:0] pin_oe,
  output logic          irq
);
  localparam logic [AW-1:0] O_STAT = AW'(0);
  localparam logic [AW-1:0] O_EDIR = AW'(1);
  localparam logic [AW-1:0] O_REN  = AW'(2);
  localparam logic [AW-1:0] O_FEN  = AW'(3);
  localparam logic [AW-1:0] O_DATA = AW'(4);
  localparam logic [AW-1:0] O_DIR  = AW'(5);
  localparam logic [AW-1:0] O_POL  = AW'(6);
  localparam logic [AW-1:0] O_SET  = AW'(7);
  localparam logic [AW-1:0] O_CLR  = AW'(8);
  localparam logic [AW-1:0] O_TGL  = AW'(9);

  logic [NL-1:0] sy1, sy2, sy3;
  logic [NL-1:0] outr, dir, ren, fen, pol, pend, edir;
  logic [NL-1:0] lvl, prv, rhit, fhit, hit, clr, wd;

  assign wd   = wdata[NL-1:0];
  assign lvl  = sy2 ^ pol;
  assign prv  = sy3 ^ pol;
  assign rhit = lvl & ~prv & ren;
  assign fhit = ~lvl & prv & fen;
  assign hit  = rhit | fhit;
  assign clr  = (wr_en && addr == O_STAT) ? wd : '0;

  assign pin_out = outr;
  assign pin_oe  = dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= pin_in; sy2 <= sy1; sy3 <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      edir <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | hit;
      edir <= (edir & ~clr & ~hit) | rhit;
      irq  <= |pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outr <= '0; dir <= '0; ren <= '0; fen <= '0; pol <= '0;
    end else if (wr_en) begin
      case (addr)
        O_REN:  ren  <= wd;
        O_FEN:  fen  <= wd;
        O_DATA: outr <= wd;
        O_DIR:  dir  <= wd;
        O_POL:  pol  <= wd;
        O_SET:  outr <= outr | wd;
        O_CLR:  outr <= outr & ~wd;
        O_TGL:  outr <= outr ^ wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        O_STAT: rdata[NL-1:0] = pend;
        O_EDIR: rdata[NL-1:0] = edir;
        O_REN:  rdata[NL-1:0] = ren;
        O_FEN:  rdata[NL-1:0] = fen;
        O_DATA: rdata[NL-1:0] = (outr & dir) | (lvl & ~dir);
        O_DIR:  rdata[NL-1:0] = dir;
        O_POL:  rdata[NL-1:0] = pol;
        default: ;
      endcase
    end
  end

  a_r2_set_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == O_SET) |=> ((pin_out & $past(wd)) == $past(wd)));

  a_r2_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == O_CLR) |=> ((pin_out & $past(wd)) == '0));

  a_r4_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(ren | fen)) == '0));

  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == O_STAT) |=> ((pend & $past(wd) & ~$past(hit)) == '0));

  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  a_r8_edir_within_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (edir & ~pend) == '0);
endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;

  logic [31:0] m_s1, m_s2, m_s3, m_out, m_dir, m_ren, m_fen, m_pol, m_pend, m_edir;
  logic m_irq;
  logic [31:0] cur_pins = '0;

  always #5 clk = ~clk;

  gpio_edge_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return m_pend;
      4'd1: return m_edir;
      4'd2: return m_ren;
      4'd3: return m_fen;
      4'd4: return (m_out & m_dir) | ((m_s2 ^ m_pol) & ~m_dir);
      4'd5: return m_dir;
      4'd6: return m_pol;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_s3 = 0; m_out = 0; m_dir = 0; m_ren = 0;
    m_fen = 0; m_pol = 0; m_pend = 0; m_edir = 0; m_irq = 0;
  endtask

  task automatic model_step(input logic we, input logic [3:0] a, input logic [31:0] d,
                            input logic [31:0] p);
    logic [31:0] lv, pv, rh, fh, ht, cl;
    lv = m_s2 ^ m_pol; pv = m_s3 ^ m_pol;
    rh = lv & ~pv & m_ren; fh = ~lv & pv & m_fen; ht = rh | fh;
    cl = (we && a == 4'd0) ? d : 32'h0;
    m_irq  = |m_pend;
    m_edir = (m_edir & ~cl & ~ht) | rh;
    m_pend = (m_pend & ~cl) | ht;
    if (we) begin
      case (a)
        4'd2: m_ren = d;
        4'd3: m_fen = d;
        4'd4: m_out = d;
        4'd5: m_dir = d;
        4'd6: m_pol = d;
        4'd7: m_out = m_out | d;
        4'd8: m_out = m_out & ~d;
        4'd9: m_out = m_out ^ d;
        default: ;
      endcase
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
  endtask

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; pin_in = cur_pins;
    @(posedge clk);
    model_step(we, a, d, cur_pins);
    #1 wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'h0);
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    addr = a; rd_en = 1; #1;
    chk(tag, rdata, exp_rd(a));
    rd_en = 0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1; #1;
    chk(tag, rdata, exp);
    rd_en = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) rd_exp(4'(a), 32'h0, "R1 reset read");
    chk("R1 reset pin_out", pin_out, 32'h0);
    chk("R1 reset pin_oe", pin_oe, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 set / clear / toggle
    cyc(1, 4'd7, 32'h0000_00F0);
    chk("R2 set", pin_out, 32'h0000_00F0);
    cyc(1, 4'd8, 32'h0000_0030);
    chk("R2 clear", pin_out, 32'h0000_00C0);
    cyc(1, 4'd9, 32'h0000_0081);
    chk("R2 toggle", pin_out, 32'h0000_0041);
    cyc(1, 4'd4, 32'h0000_00F0);
    chk("R2 data write", pin_out, 32'h0000_00F0);
    rd_exp(4'd7, 32'h0, "R11 set reads zero");
    rd_exp(4'd9, 32'h0, "R11 toggle reads zero");

    // R3 direction and data read
    cyc(1, 4'd5, 32'h0000_FFFF);
    chk("R3 pin_oe", pin_oe, 32'h0000_FFFF);
    cur_pins = 32'hABCD_0000;
    cyc(0, 4'd0, 0);
    rd_exp(4'd4, 32'h0000_00F0, "R3 not yet visible");
    cyc(0, 4'd0, 0);
    rd_exp(4'd4, 32'hABCD_00F0, "R3 data mux");
    // R10 polarity
    cyc(1, 4'd6, 32'hFFFF_0000);
    rd_exp(4'd4, 32'h5432_00F0, "R10 polarity data");
    idle(3);
    rd_exp(4'd0, 32'h0, "R10 no edge from polarity");
    cyc(1, 4'd6, 32'h0);
    cyc(1, 4'd5, 32'h0);
    cur_pins = 32'h0; idle(4);
    rd_exp(4'd0, 32'h0, "R4 nothing pending with enables off");

    // R4 rising only on bit 0, R9 timing
    cyc(1, 4'd2, 32'h1);
    cur_pins = 32'h1;
    cyc(0, 4'd0, 0); cyc(0, 4'd0, 0);
    rd_exp(4'd0, 32'h0, "R9 pending not before k+2");
    cyc(0, 4'd0, 0);
    rd_exp(4'd0, 32'h1, "R4 rising pending");
    rd_exp(4'd1, 32'h1, "R8 rising direction");
    chk("R9 irq not yet", {31'h0, irq}, 32'h0);
    cyc(0, 4'd0, 0);
    chk("R9 irq high", {31'h0, irq}, 32'h1);
    cyc(1, 4'd1, 32'h0);
    rd_exp(4'd1, 32'h1, "R8 edge dir write ignored");
    cyc(1, 4'd0, 32'hFFFF_FFFE);
    rd_exp(4'd0, 32'h1, "R6 zero bit keeps flag");
    cyc(1, 4'd0, 32'h1);
    rd_exp(4'd0, 32'h0, "R6 one clears flag");
    rd_exp(4'd1, 32'h0, "R8 cleared with flag");
    chk("R9 irq still high one cycle", {31'h0, irq}, 32'h1);
    cyc(0, 4'd0, 0);
    chk("R9 irq low", {31'h0, irq}, 32'h0);
    cur_pins = 32'h0; idle(4);
    rd_exp(4'd0, 32'h0, "R4 falling ignored when only rising on");

    // R5 falling only
    cyc(1, 4'd2, 32'h0);
    cyc(1, 4'd3, 32'h1);
    cur_pins = 32'h1; idle(4);
    rd_exp(4'd0, 32'h0, "R5 rising ignored when only falling on");
    cur_pins = 32'h0; idle(3);
    rd_exp(4'd0, 32'h1, "R5 falling pending");
    rd_exp(4'd1, 32'h0, "R8 falling direction");
    cyc(1, 4'd0, 32'h1);

    // R5 both, R7 collision
    cyc(1, 4'd2, 32'h1);
    cur_pins = 32'h1; idle(3);
    rd_exp(4'd0, 32'h1, "R5 both rising");
    rd_exp(4'd1, 32'h1, "R8 both rising dir");
    cur_pins = 32'h0;
    cyc(0, 4'd0, 0); cyc(0, 4'd0, 0);
    cyc(1, 4'd0, 32'h1);
    rd_exp(4'd0, 32'h1, "R7 edge beats clear");
    rd_exp(4'd1, 32'h0, "R8 collision falling dir");
    cyc(1, 4'd0, 32'h1);
    rd_exp(4'd0, 32'h0, "R7 later clear works");
    cyc(1, 4'd12, 32'hFFFF_FFFF);
    chk("R11 unused write no effect", pin_out, 32'h0000_00F0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      a = 4'($urandom % 12);
      d = $urandom;
      cur_pins = cur_pins ^ ($urandom & $urandom & $urandom);
      cyc(($urandom % 2) == 0, a, d);
      rd_chk(4'($urandom % 16), "R11 random read");
      chk("R9 random irq", {31'h0, irq}, {31'h0, m_irq});
      chk("R2 random pin_out", pin_out, m_out);
      chk("R3 random pin_oe", pin_oe, m_dir);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule